// File: doc/BRIEF.md
# Receive Character Queue with Per-Byte Error Tags

This block holds characters delivered by a serial receiver until the host reads them. Every stored entry carries the data byte together with three error flags (parity, framing, break). The entry at the head of the queue is shown on the read-data output, and its flags appear in the status word. When the host pops the head, the next entry's byte and flags become visible right after that clock edge. The flags always belong to the byte the host is about to read.

A queue-enable input picks between two modes. In one, the full queue of `DEPTH` entries is in use. In the other, the block acts as a single holding register. A data-request interrupt can fire either for every waiting character or only once the fill level reaches one of four programmable thresholds. An enable input gates the interrupt. A status-read strobe clears the sticky overrun flag, and a clear strobe empties the queue.

Top module: `rxq_tagged`

## Requirements
- R1: After reset the queue is empty, `line_stat` is 0, `level` is 0 and `rx_irq` is 0.
- R2: `rd_data` always shows the oldest unread byte, and bytes leave in the order they were written.
- R3: `line_stat[4:2]` shows the head entry's tags: bit 2 is parity, bit 3 is framing and bit 4 is break, taken from `wr_tags[0]`, `[1]` and `[2]`. They switch to the next entry's tags in the first cycle after a pop, and they read 0 when the queue is empty.
- R4: `line_stat[0]` is 1 exactly when the queue holds at least one entry.
- R5: With `fifo_en`=1 the queue accepts `DEPTH` (32) entries. With `fifo_en`=0 it accepts one.
- R6: A write while the queue is full, with no pop in the same cycle, is dropped and sets `line_stat[1]`. A `stat_rd` pulse clears that flag.
- R7: With `irq_on_thr`=0, `rx_irq` is high whenever the queue is non-empty and `irq_en`=1.
- R8: With `irq_on_thr`=1 and `fifo_en`=1, `rx_irq` rises when `level` reaches the trigger picked by `thr_sel`: 0→1, 1→8, 2→16, 3→28. With `fifo_en`=0 the interrupt follows the R7 rule.
- R9: `irq_en`=0 holds `rx_irq` low.
- R10: `flush` empties the queue and clears the tags and the overrun flag. A write in the same cycle as `flush` is discarded.
- R11: Changing `fifo_en` empties the queue.
- R12: A write and a pop in the same cycle on a full queue are both taken, and `level` stays the same.
- R13: A pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: full queue, 0: single holding register |
| irq_on_thr | input | 1 | 1: interrupt at the fill threshold, 0: per character |
| thr_sel | input | 2 | Trigger level select |
| irq_en | input | 1 | Data interrupt enable |
| wr_valid | input | 1 | Received character strobe |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | {break, framing, parity} flags of the byte |
| rd_pop | input | 1 | Host read of the data register |
| stat_rd | input | 1 | Host read of the status word |
| flush | input | 1 | Empty the queue |
| rd_data | output | 8 | Head byte (0 when empty) |
| line_stat | output | 5 | {tags[2:0], overrun, data ready} |
| level | output | 6 | Number of stored entries |
| rx_irq | output | 1 | Data-request interrupt |

## Verification
On every cycle, the assertions check that the fill level never exceeds the mode's capacity and that the pointer distance matches the level. They also check that the head byte changes only on a pop or a clear, that overrun rises only after a rejected write, and that the interrupt never fires while disabled or empty. Some properties need whole sequences and are shown only by the bench scenarios: first-in first-out order with tags attached, the exact threshold crossings, a full-queue push and pop in the same cycle, and the effect of a mode change or a clear on stored data.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_tags_t;

   localparam int TAG_W = $bits(rx_tags_t);
endpackage

// File: rtl/rxq_level.sv
module rxq_level #(
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          flush,
   input  logic          wr_valid,
   input  logic          rd_pop,
   input  logic          stat_rd,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          clr,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          overrun
);
   logic          mode_q;
   logic [CW-1:0] cap;
   logic          full;

   assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
   assign clr     = flush | (fifo_en != mode_q);
   assign empty   = (count == '0);
   assign full    = (count >= cap);
   assign pop_ok  = rd_pop & ~empty & ~clr;
   assign push_ok = wr_valid & ~clr & (~full | pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         if (clr) begin
            count   <= '0;
            overrun <= 1'b0;
         end else begin
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (wr_valid && !push_ok) overrun <= 1'b1;
            else if (stat_rd)         overrun <= 1'b0;
         end
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en == mode_q) |-> (count <= cap));

   // R6
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(wr_valid && full && !clr));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 32,
   parameter int ENT_W = 11,
   parameter int AW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push_ok,
   input  logic             pop_ok,
   input  logic [ENT_W-1:0] wr_ent,
   output logic [ENT_W-1:0] head_ent,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    rd_ptr
);
   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push_ok && !clr) begin
         mem[wr_ptr] <= wr_ent;
      end
   end

   assign head_ent = mem[rd_ptr];
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int CW     = 6,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 8,
   parameter int TRIG_2 = 16,
   parameter int TRIG_3 = 28
) (
   input  logic          fifo_en,
   input  logic          irq_on_thr,
   input  logic          irq_en,
   input  logic [1:0]    thr_sel,
   input  logic [CW-1:0] count,
   input  logic          empty,
   output logic          irq
);
   logic [CW-1:0] trig;

   always_comb begin
      case (thr_sel)
         2'd0:    trig = CW'(TRIG_0);
         2'd1:    trig = CW'(TRIG_1);
         2'd2:    trig = CW'(TRIG_2);
         default: trig = CW'(TRIG_3);
      endcase
   end

   assign irq = irq_en & ~empty & (~fifo_en | ~irq_on_thr | (count >= trig));
endmodule

// File: rtl/rxq_tagged.sv
module rxq_tagged
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 8,
   parameter int TRIG_2 = 16,
   parameter int TRIG_3 = 28
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fifo_en,
   input  logic                  irq_on_thr,
   input  logic [1:0]            thr_sel,
   input  logic                  irq_en,
   input  logic                  wr_valid,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [2:0]            wr_tags,
   input  logic                  rd_pop,
   input  logic                  stat_rd,
   input  logic                  flush,
   output logic [DATA_W-1:0]     rd_data,
   output logic [4:0]            line_stat,
   output logic [$clog2(DEPTH):0] level,
   output logic                  rx_irq
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = AW + 1;
   localparam int ENT_W = DATA_W + TAG_W;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("rxq_tagged: DEPTH must be a power of two of at least 2");
      end
      if (TRIG_0 < 1 || TRIG_1 > DEPTH || TRIG_2 > DEPTH || TRIG_3 > DEPTH) begin : g_bad_trig
         $error("rxq_tagged: trigger levels must lie in 1..DEPTH");
      end
   endgenerate

   logic             push_ok, pop_ok, clr, empty, overrun;
   logic [CW-1:0]    count;
   logic [ENT_W-1:0] head_ent;
   logic [AW-1:0]    wr_ptr, rd_ptr;
   rx_tags_t         head_tags;

   rxq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
      .wr_valid(wr_valid), .rd_pop(rd_pop), .stat_rd(stat_rd),
      .push_ok(push_ok), .pop_ok(pop_ok), .clr(clr),
      .count(count), .empty(empty), .overrun(overrun)
   );

   rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push_ok(push_ok), .pop_ok(pop_ok),
      .wr_ent({wr_tags, wr_data}), .head_ent(head_ent),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
   );

   rxq_irq #(.CW(CW), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1),
             .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)) u_irq (
      .fifo_en(fifo_en), .irq_on_thr(irq_on_thr), .irq_en(irq_en),
      .thr_sel(thr_sel), .count(count), .empty(empty), .irq(rx_irq)
   );

   assign head_tags = empty ? '0 : rx_tags_t'(head_ent[ENT_W-1:DATA_W]);
   assign rd_data   = empty ? '0 : head_ent[DATA_W-1:0];
   assign line_stat = {head_tags.brk, head_tags.frm, head_tags.par, overrun, ~empty};
   assign level     = count;

   // R2
   ptr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) == count[AW-1:0]);

   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !pop_ok && !clr) |=> $stable(rd_data));

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (irq_en && line_stat[0]));

   // R13
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_pop && !wr_valid) |=> (level == '0));
endmodule

// File: tb/rxq_tagged_bench.sv
module rxq_tagged_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1, irq_on_thr = 1'b0, irq_en = 1'b1;
   logic [1:0] thr_sel = 2'd0;
   logic       wr_valid = 1'b0, rd_pop = 1'b0, stat_rd = 1'b0, flush = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] wr_tags = '0;
   logic [7:0] rd_data;
   logic [4:0] line_stat;
   logic [5:0] level;
   logic       rx_irq;

   int checks = 0;
   int errors = 0;
   logic [10:0] sb [$];
   int cap_m = 32;

   always #2.5 clk = ~clk;

   rxq_tagged u_rxq_tagged (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .irq_on_thr(irq_on_thr),
      .thr_sel(thr_sel), .irq_en(irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_tags(wr_tags), .rd_pop(rd_pop), .stat_rd(stat_rd), .flush(flush),
      .rd_data(rd_data), .line_stat(line_stat), .level(level), .rx_irq(rx_irq)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: one write, model mirrors acceptance
   task automatic push(logic [7:0] d, logic [2:0] t);
      wr_valid = 1'b1; wr_data = d; wr_tags = t;
      if (sb.size() < cap_m) sb.push_back({t, d});
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // monitor: compare the head against the scoreboard, then pop it
   task automatic pop_cmp(string req);
      logic [10:0] e;
      e = sb.pop_front();
      check({req, " data"}, rd_data, e[7:0]);
      check({req, " tags"}, line_stat[4:2], e[10:8]);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   initial begin
      #(5ns * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 stat", line_stat, 0);
      check("R1 level", level, 0);
      check("R1 irq", rx_irq, 0);

      // R2 R3 R4 R7 per-character interrupt
      push(8'hA1, 3'b001);
      check("R7 irq after one char", rx_irq, 1);
      check("R4 ready", line_stat[0], 1);
      push(8'hB2, 3'b110);
      push(8'hC3, 3'b000);
      irq_en = 1'b0;
      @(negedge clk);
      check("R9 irq gated", rx_irq, 0);
      irq_en = 1'b1;
      pop_cmp("R2 R3 first");
      pop_cmp("R3 second new head tags");
      pop_cmp("R2 third");
      check("R3 tags empty", line_stat[4:2], 0);
      check("R4 empty", line_stat[0], 0);

      // R13
      rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
      check("R13 pop empty", level, 0);

      // R8 threshold 8
      irq_on_thr = 1'b1; thr_sel = 2'd1;
      for (int i = 0; i < 7; i++) push(8'(i), 3'(i));
      check("R8 below 8", rx_irq, 0);
      push(8'h07, 3'b111);
      check("R8 at 8", rx_irq, 1);
      thr_sel = 2'd3;
      @(negedge clk);
      check("R8 sel28 at 8", rx_irq, 0);
      for (int i = 8; i < 28; i++) push(8'(i), 3'(i));
      check("R8 at 28", rx_irq, 1);
      for (int i = 28; i < 32; i++) push(8'(i), 3'(i));
      check("R5 full level", level, 32);
      push(8'hEE, 3'b101);
      check("R6 overrun set", line_stat[1], 1);
      check("R6 dropped", level, 32);
      // R12 push and pop together at full
      begin
         logic [10:0] e;
         e = sb.pop_front();
         check("R12 head data", rd_data, e[7:0]);
         sb.push_back({3'b010, 8'h5A});
         rd_pop = 1'b1; wr_valid = 1'b1; wr_data = 8'h5A; wr_tags = 3'b010;
         @(negedge clk);
         rd_pop = 1'b0; wr_valid = 1'b0;
         check("R12 level kept", level, 32);
      end
      stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
      check("R6 overrun cleared", line_stat[1], 0);
      while (sb.size() > 0) pop_cmp("R2 drain");
      check("R2 drained", level, 0);

      // R10 flush
      push(8'h11, 3'b100);
      push(8'h22, 3'b010);
      flush = 1'b1; wr_valid = 1'b1; wr_data = 8'h33;
      @(negedge clk);
      flush = 1'b0; wr_valid = 1'b0;
      sb.delete();
      check("R10 level", level, 0);
      check("R10 stat", line_stat, 0);

      // R11 mode change, R5 single holding register
      push(8'h44, 3'b001);
      push(8'h55, 3'b001);
      fifo_en = 1'b0; cap_m = 1;
      @(negedge clk);
      sb.delete();
      check("R11 cleared", level, 0);
      push(8'h66, 3'b100);
      check("R8 per char in single mode", rx_irq, 1);
      push(8'h77, 3'b011);
      check("R5 single level", level, 1);
      check("R6 single overrun", line_stat[1], 1);
      pop_cmp("R5 single head");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule